// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block runs one command at a time through a device mailbox that is reached over a simple register read/write port. A caller hands it an opcode, an input length and the largest output length it will accept. The sequencer first waits for the device's doorbell to drop, with a time limit. It then checks the device's health word. It looks at the doorbell once more and writes the command word. Next it rings the doorbell and waits, again with a time limit, for the device to clear it. Finally it collects the return code and, when that code is zero, the output length. Payload bytes are not moved here. Only their count is handled.

The outcome comes back as a one-cycle completion pulse that carries a two-bit status, the device return code and the granted output length. The sequencer is busy from the cycle after it accepts a request until the cycle after its completion pulse. A request offered while it is busy is dropped.

Top module: `mbx_cmd_engine`

## Requirements
- R1: After reset, `busy`, `doneValid` and `regReq` are all low.
- R2: A request is accepted only while `busy` is low. `busy` rises on the next cycle and falls on the cycle after `doneValid`. A `reqValid` seen while busy has no effect: it causes no extra completion and does not change the opcode that gets written.
- R3: The register map is control at 0, command at 1, return status at 2 and device health at 3. A successful command makes these accesses in this order: one or more control reads, a health read, a control read, a command write, a control write, one or more control reads, a status read and a command read. Each access holds its request until `regAck`.
- R4: The health word counts as up only when bit 4 (mailbox ready) is 1 and bits [3:2] (media state) equal 01. If the device is not up, the command ends with status 1 (busy) and the command register is never written.
- R5: If the device is up but bit 0 (fatal), bit 1 (firmware halted) or any of bits [7:5] (reset wanted) is set, the command ends with status 3 (fault).
- R6: If the control read that follows the health read shows the doorbell (bit 0) set, the command ends with status 1 and the command register is not written.
- R7: Each doorbell wait has a limit of LIMIT cycles, counted from the start of that wait. The first control read that completes after the limit is the final sample. If it shows the doorbell clear, the sequence goes on. If it shows the doorbell set, the command ends with status 2 (timeout). No timeout is reported before LIMIT cycles have passed.
- R8: A nonzero return code in status bits [47:32] completes the command with status 0. The code is reported, the output length is 0, and the command register is not read back.
- R9: The granted output length is the smallest of the requested length, CAP_BYTES and the device length in command bits [36:16]. It is therefore 0 whenever the requested or the reported length is 0.
- R10: Status codes are 0 ok, 1 busy, 2 timeout and 3 fault. `doneValid` is high for exactly one cycle per command. When the status is not 0, the return code and the length are 0.
- R11: The command word carries the opcode in bits [15:0] and the input length in bits [36:16]. The doorbell write puts the value 1 into the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request strobe |
| reqOpcode | input | 16 | Command opcode |
| reqInLen | input | 21 | Input payload length |
| reqOutLen | input | 21 | Largest output length the caller accepts |
| busy | output | 1 | A command is in progress |
| regReq | output | 1 | Register access request |
| regWe | output | 1 | 1 = write, 0 = read |
| regAddr | output | 2 | Register index |
| regWdata | output | 64 | Write data |
| regRdata | input | 64 | Read data, valid with regAck |
| regAck | input | 1 | Access complete |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | Completion status |
| doneRc | output | 16 | Device return code |
| doneOutLen | output | 21 | Granted output length |

## Verification
The length clamp is swept over every pairing of requested and reported lengths taken from zero, one, a small value, the capacity and its two neighbours, and the largest 21-bit value. This shows which of the three operands won in each case. The health word is driven with each missing-ready pattern and then each fault bit on its own, so a busy outcome can be told apart from a fault outcome. The doorbell is held set before the command, held set after it forever, re-raised between the health read and the command write, and cleared during a control read that is stalled past the limit. These cases separate the timeout path, the early-busy path and the final-sample rule. Sending a nonzero return code, and issuing a second request while busy, shows whether the length read is skipped and whether the second request is dropped.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 21;
  localparam int OPC_W  = 16;
  localparam int RC_W   = 16;

  // register indices
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_DEV  = 2'd3;

  // field positions
  localparam int CMD_LEN_LSB = 16;
  localparam int RC_LSB      = 32;
  localparam int DEV_FATAL   = 0;
  localparam int DEV_HALT    = 1;
  localparam int DEV_MEDIA   = 2;   // two bits, 01 = ready
  localparam int DEV_MBRDY   = 4;
  localparam int DEV_RST     = 5;   // three bits, nonzero = reset wanted

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_BUSY  = 2'd1,
    ST_TMO   = 2'd2,
    ST_FAULT = 2'd3
  } cmdStatus_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PREPOLL, S_HEALTH, S_RECHK, S_WRCMD,
    S_RING, S_POSTPOLL, S_RDSTAT, S_RDLEN, S_DONE
  } seqState_e;

  // control -> datapath
  typedef struct packed {
    logic              latchReq;
    logic              clrTmr;
    logic              tmrRun;
    logic              capRc;
    logic              capLen;
    logic              setResult;
    cmdStatus_e        result;
    logic              busReq;
    logic              busWe;
    logic [ADDR_W-1:0] busAddr;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic dbSet;
    logic devUp;
    logic devSick;
    logic rcNz;
    logic expired;
  } seqFlags_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       regAck,
  input  seqFlags_t  flags,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       doneValid
);
  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy      = (state != S_IDLE);
  assign doneValid = (state == S_DONE);

  always_comb begin
    nextState   = state;
    stb         = '0;
    stb.result  = ST_OK;
    stb.busAddr = A_CTRL;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stb.clrTmr   = 1'b1;
          nextState    = S_PREPOLL;
        end
      end
      S_PREPOLL, S_POSTPOLL: begin
        stb.busReq  = 1'b1;
        stb.busAddr = A_CTRL;
        stb.tmrRun  = 1'b1;
        if (regAck) begin
          if (!flags.dbSet) begin
            nextState = (state == S_PREPOLL) ? S_HEALTH : S_RDSTAT;
          end else if (flags.expired) begin
            stb.setResult = 1'b1;
            stb.result    = ST_TMO;
            nextState     = S_DONE;
          end
        end
      end
      S_HEALTH: begin
        stb.busReq  = 1'b1;
        stb.busAddr = A_DEV;
        if (regAck) begin
          if (!flags.devUp) begin
            stb.setResult = 1'b1;
            stb.result    = ST_BUSY;
            nextState     = S_DONE;
          end else if (flags.devSick) begin
            stb.setResult = 1'b1;
            stb.result    = ST_FAULT;
            nextState     = S_DONE;
          end else begin
            nextState = S_RECHK;
          end
        end
      end
      S_RECHK: begin
        stb.busReq  = 1'b1;
        stb.busAddr = A_CTRL;
        if (regAck) begin
          if (flags.dbSet) begin
            stb.setResult = 1'b1;
            stb.result    = ST_BUSY;
            nextState     = S_DONE;
          end else begin
            nextState = S_WRCMD;
          end
        end
      end
      S_WRCMD: begin
        stb.busReq  = 1'b1;
        stb.busWe   = 1'b1;
        stb.busAddr = A_CMD;
        if (regAck) nextState = S_RING;
      end
      S_RING: begin
        stb.busReq  = 1'b1;
        stb.busWe   = 1'b1;
        stb.busAddr = A_CTRL;
        if (regAck) begin
          stb.clrTmr = 1'b1;
          nextState  = S_POSTPOLL;
        end
      end
      S_RDSTAT: begin
        stb.busReq  = 1'b1;
        stb.busAddr = A_STAT;
        if (regAck) begin
          stb.capRc = 1'b1;
          if (flags.rcNz) begin
            stb.setResult = 1'b1;
            nextState     = S_DONE;
          end else begin
            nextState = S_RDLEN;
          end
        end
      end
      S_RDLEN: begin
        stb.busReq  = 1'b1;
        stb.busAddr = A_CMD;
        if (regAck) begin
          stb.capLen    = 1'b1;
          stb.setResult = 1'b1;
          nextState     = S_DONE;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
#(
  parameter int              TMR_W     = 8,
  parameter logic [TMR_W-1:0] TMR_LIMIT = '1,
  parameter int              CAP_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [OPC_W-1:0]  reqOpcode,
  input  logic [LEN_W-1:0]  reqInLen,
  input  logic [LEN_W-1:0]  reqOutLen,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] regWdata,
  output seqFlags_t         flags,
  output logic [1:0]        doneStatus,
  output logic [RC_W-1:0]   doneRc,
  output logic [LEN_W-1:0]  doneOutLen
);
  localparam logic [LEN_W-1:0] CAP_V = LEN_W'(CAP_BYTES);
  localparam int CMD_PAD = DATA_W - CMD_LEN_LSB - LEN_W;

  logic [OPC_W-1:0] opcQ;
  logic [LEN_W-1:0] inLenQ, outLenQ, lenQ;
  logic [RC_W-1:0]  rcQ;
  cmdStatus_e       statQ;
  logic [TMR_W-1:0] tmr;
  logic [LEN_W-1:0] devLen, capA, clamped;
  logic             unusedBits;

  // decode of the word returned by the current read
  assign devLen        = regRdata[CMD_LEN_LSB +: LEN_W];
  assign flags.dbSet   = regRdata[0];
  assign flags.devUp   = regRdata[DEV_MBRDY] && (regRdata[DEV_MEDIA +: 2] == 2'b01);
  assign flags.devSick = regRdata[DEV_FATAL] || regRdata[DEV_HALT] ||
                         (regRdata[DEV_RST +: 3] != 3'd0);
  assign flags.rcNz    = (regRdata[RC_LSB +: RC_W] != '0);
  assign flags.expired = (tmr >= TMR_LIMIT);
  assign unusedBits    = ^{regRdata[63:48], regRdata[15:8]};

  // three-way minimum
  assign capA    = (outLenQ < CAP_V) ? outLenQ : CAP_V;
  assign clamped = (capA < devLen) ? capA : devLen;

  assign regWdata = (stb.busAddr == A_CMD) ?
                    {{CMD_PAD{1'b0}}, inLenQ, opcQ} : {{(DATA_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcQ    <= '0;
      inLenQ  <= '0;
      outLenQ <= '0;
      lenQ    <= '0;
      rcQ     <= '0;
      statQ   <= ST_OK;
      tmr     <= '0;
    end else begin
      if (stb.latchReq) begin
        opcQ    <= reqOpcode;
        inLenQ  <= reqInLen;
        outLenQ <= reqOutLen;
        lenQ    <= '0;
        rcQ     <= '0;
        statQ   <= ST_OK;
      end
      if (stb.clrTmr)                     tmr <= '0;
      else if (stb.tmrRun && !flags.expired) tmr <= tmr + 1'b1;
      if (stb.capRc)     rcQ   <= regRdata[RC_LSB +: RC_W];
      if (stb.capLen)    lenQ  <= clamped;
      if (stb.setResult) statQ <= stb.result;
    end
  end

  assign doneStatus = statQ;
  assign doneRc     = rcQ;
  assign doneOutLen = lenQ;
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
  import mbx_pkg::*;
#(
  parameter longint CLK_HZ          = 200_000_000,
  parameter int     TIMEOUT_MS      = 2000,
  parameter int     SIM_TIMEOUT_CYC = 0,
  parameter int     CAP_BYTES       = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [15:0] reqOpcode,
  input  logic [20:0] reqInLen,
  input  logic [20:0] reqOutLen,
  output logic        busy,
  output logic        regReq,
  output logic        regWe,
  output logic [1:0]  regAddr,
  output logic [63:0] regWdata,
  input  logic [63:0] regRdata,
  input  logic        regAck,
  output logic        doneValid,
  output logic [1:0]  doneStatus,
  output logic [15:0] doneRc,
  output logic [20:0] doneOutLen
);
  localparam longint LIMIT = (SIM_TIMEOUT_CYC != 0) ? longint'(SIM_TIMEOUT_CYC)
                                                    : (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int TMR_W = $clog2(LIMIT + 1);
  localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(LIMIT);

  seqStrobe_t stb;
  seqFlags_t  flags;

  mbx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .regAck    (regAck),
    .flags     (flags),
    .stb       (stb),
    .busy      (busy),
    .doneValid (doneValid)
  );

  mbx_dpath #(
    .TMR_W     (TMR_W),
    .TMR_LIMIT (TMR_LIMIT),
    .CAP_BYTES (CAP_BYTES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqOpcode  (reqOpcode),
    .reqInLen   (reqInLen),
    .reqOutLen  (reqOutLen),
    .regRdata   (regRdata),
    .regWdata   (regWdata),
    .flags      (flags),
    .doneStatus (doneStatus),
    .doneRc     (doneRc),
    .doneOutLen (doneOutLen)
  );

  assign regReq  = stb.busReq;
  assign regWe   = stb.busWe;
  assign regAddr = stb.busAddr;
endmodule

// File: rtl/mbx_cmd_engine_chk.sv
module mbx_cmd_engine_chk #(
  parameter int CAP_BYTES = 4096
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        regReq,
  input logic        regWe,
  input logic [1:0]  regAddr,
  input logic [63:0] regWdata,
  input logic        regAck,
  input logic        doneValid,
  input logic [1:0]  doneStatus,
  input logic [15:0] doneRc,
  input logic [20:0] doneOutLen
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!regReq && !doneValid));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !doneValid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regAddr) && $stable(regWe)));

  p_ring_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWe && regAddr == 2'd0) |-> (regWdata == 64'd1));

  p_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneOutLen <= 21'(CAP_BYTES)));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && !busy));

  p_fail_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus != 2'd0) |-> (doneRc == 16'd0 && doneOutLen == 21'd0));
endmodule

bind mbx_cmd_engine mbx_cmd_engine_chk #(.CAP_BYTES(CAP_BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .regReq     (regReq),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .regAck     (regAck),
  .doneValid  (doneValid),
  .doneStatus (doneStatus),
  .doneRc     (doneRc),
  .doneOutLen (doneOutLen)
);

// File: tb/mbx_cmd_engine_test.sv
`timescale 1ns/1ps
module mbx_cmd_engine_test;
  localparam int LIMIT = 40;
  localparam int CAP   = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqOpcode = '0;
  logic [20:0] reqInLen = '0, reqOutLen = '0;
  logic        busy, regReq, regWe, doneValid;
  logic [1:0]  regAddr, doneStatus;
  logic [63:0] regWdata;
  logic [63:0] regRdata = '0;
  logic        regAck = 1'b0;
  logic [15:0] doneRc;
  logic [20:0] doneOutLen;

  always #2.5 clk = ~clk;

  mbx_cmd_engine #(.SIM_TIMEOUT_CYC(LIMIT), .CAP_BYTES(CAP)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .reqInLen(reqInLen), .reqOutLen(reqOutLen), .busy(busy), .regReq(regReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regAck(regAck), .doneValid(doneValid), .doneStatus(doneStatus),
    .doneRc(doneRc), .doneOutLen(doneOutLen)
  );

  // device model configuration
  int          preHold = 0, postHold = 3, ackDelay = 0;
  bit          preNever = 0, postNever = 0, setDbOnDev = 0, kick = 0;
  logic [7:0]  devStat = 8'h14;
  logic [15:0] rcVal = '0;
  logic [20:0] devLen = '0;

  // device model state
  logic        dbBit = 0, dbNever = 0;
  int          dbCnt = 0, waitCnt = 0, logCnt = 0, doneCount = 0;
  logic [2:0]  opLog [0:63];
  logic [63:0] lastCmd = '0;

  always @(posedge clk) begin
    if (doneValid) doneCount <= doneCount + 1;
    if (kick) begin
      dbBit   <= (preHold != 0) || preNever;
      dbCnt   <= preHold;
      dbNever <= preNever;
      logCnt  <= 0;
    end else if (dbBit && !dbNever) begin
      if (dbCnt <= 1) dbBit <= 1'b0;
      else            dbCnt <= dbCnt - 1;
    end
    if (regAck) regAck <= 1'b0;
    else if (regReq) begin
      if (!regWe && regAddr == 2'd0 && waitCnt < ackDelay) waitCnt <= waitCnt + 1;
      else begin
        waitCnt <= 0;
        regAck  <= 1'b1;
        if (logCnt < 64) opLog[logCnt] <= {regWe, regAddr};
        logCnt <= logCnt + 1;
        if (regWe) begin
          if (regAddr == 2'd1) lastCmd <= regWdata;
          else if (regAddr == 2'd0 && regWdata[0]) begin
            dbBit <= 1'b1; dbCnt <= postHold; dbNever <= postNever;
          end
        end else begin
          case (regAddr)
            2'd0: regRdata <= {63'd0, dbBit};
            2'd1: regRdata <= {27'd0, devLen, 16'd0};
            2'd2: regRdata <= {16'd0, rcVal, 32'd0};
            default: begin
              regRdata <= {56'd0, devStat};
              if (setDbOnDev) begin dbBit <= 1'b1; dbNever <= 1'b1; end
            end
          endcase
        end
      end
    end
  end

  int tests = 0, fails = 0;
  longint cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic bit logHas(input logic [2:0] code);
    for (int i = 0; i < logCnt && i < 64; i++) if (opLog[i] == code) return 1'b1;
    return 1'b0;
  endfunction

  logic [1:0]  gotStat;
  logic [15:0] gotRc;
  logic [20:0] gotLen;
  int gotPulses, gotCyc;
  bit busySeen;

  task automatic runCmd(input logic [15:0] opc, input logic [20:0] inL,
                        input logic [20:0] outL, input int dupAt);
    int startDone;
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
    startDone = doneCount;
    reqValid = 1; reqOpcode = opc; reqInLen = inL; reqOutLen = outL;
    @(negedge clk); reqValid = 0;
    busySeen = busy;
    gotCyc = 1;
    while (!doneValid && gotCyc < 3000) begin
      if (dupAt != 0 && gotCyc == dupAt) begin
        reqValid = 1; reqOpcode = ~opc; reqInLen = ~inL;
      end else reqValid = 0;
      @(negedge clk); gotCyc++;
    end
    reqValid = 0;
    chk(doneValid, "R10 completion seen", doneValid, 1);
    gotStat = doneStatus; gotRc = doneRc; gotLen = doneOutLen;
    repeat (4) @(negedge clk);
    gotPulses = doneCount - startDone;
    chk(gotPulses == 1, "R10 single pulse", gotPulses, 1);
    chk(busySeen && !busy, "R2 busy window", {busySeen, busy}, 2);
  endtask

  task automatic defaults();
    preHold = 0; preNever = 0; postHold = 3; postNever = 0; ackDelay = 0;
    setDbOnDev = 0; devStat = 8'h14; rcVal = '0; devLen = '0;
  endtask

  initial begin
    int vals [7] = '{0, 1, 7, 63, 64, 65, 2097151};
    logic [7:0] notUp [3] = '{8'h04, 8'h10, 8'h18};
    logic [7:0] sick [3]  = '{8'h15, 8'h16, 8'h54};
    repeat (3) @(negedge clk);
    chk(!busy && !doneValid && !regReq, "R1 reset state", {busy, doneValid, regReq}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !regReq, "R1 idle after reset", {busy, regReq}, 0);

    // basic command: order and command word
    defaults(); devLen = 10; postHold = 5;
    runCmd(16'h1234, 21'h1ABCD, 21'd20, 0);
    chk(gotStat == 0 && gotLen == 10 && gotRc == 0, "R9 basic grant", gotLen, 10);
    chk(logCnt >= 7 && opLog[0] == 3'd0 && opLog[1] == 3'd3 && opLog[2] == 3'd0 &&
        opLog[3] == 3'd5 && opLog[4] == 3'd4, "R3 leading access order",
        {opLog[0], opLog[1], opLog[2], opLog[3], opLog[4]}, 15'o03054);
    chk(opLog[logCnt-2] == 3'd2 && opLog[logCnt-1] == 3'd1, "R3 trailing access order",
        {opLog[logCnt-2], opLog[logCnt-1]}, 6'o21);
    chk(lastCmd[15:0] == 16'h1234 && lastCmd[36:16] == 21'h1ABCD && lastCmd[63:37] == 0,
        "R11 command word", lastCmd, {27'd0, 21'h1ABCD, 16'h1234});

    // clamp sweep
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 7; b++) begin
        int e;
        defaults(); devLen = 21'(vals[b]);
        e = vals[a] < CAP ? vals[a] : CAP;
        e = e < vals[b] ? e : vals[b];
        runCmd(16'h0042, 21'd0, 21'(vals[a]), 0);
        chk(gotStat == 0 && gotLen == 21'(e), "R9 clamp", gotLen, e);
      end
    end

    // doorbell busy before command, clears in time
    defaults(); preHold = 12; devLen = 5;
    runCmd(16'h0001, 21'd3, 21'd9, 0);
    chk(gotStat == 0 && gotLen == 5, "R7 pre-wait clears", gotStat, 0);
    chk(opLog[0] == 3'd0 && opLog[1] == 3'd0, "R3 repeated control reads", opLog[1], 0);

    // doorbell never clears before command
    defaults(); preNever = 1;
    runCmd(16'h0002, 21'd3, 21'd9, 0);
    chk(gotStat == 2, "R7 pre-wait timeout", gotStat, 2);
    chk(!logHas(3'd5), "R7 no command write on timeout", logHas(3'd5), 0);
    chk(gotCyc >= LIMIT, "R7 not early", gotCyc, LIMIT);

    // not up
    for (int i = 0; i < 3; i++) begin
      defaults(); devStat = notUp[i];
      runCmd(16'h0003, 21'd1, 21'd1, 0);
      chk(gotStat == 1, "R4 not ready busy", gotStat, 1);
      chk(!logHas(3'd5), "R4 no command write", logHas(3'd5), 0);
    end

    // up but sick
    for (int i = 0; i < 3; i++) begin
      defaults(); devStat = sick[i];
      runCmd(16'h0004, 21'd1, 21'd1, 0);
      chk(gotStat == 3 && gotRc == 0 && gotLen == 0, "R5 fault status", gotStat, 3);
    end

    // doorbell re-raised before command write
    defaults(); setDbOnDev = 1;
    runCmd(16'h0005, 21'd1, 21'd1, 0);
    chk(gotStat == 1, "R6 recheck busy", gotStat, 1);
    chk(!logHas(3'd5), "R6 no command write", logHas(3'd5), 0);

    // doorbell never clears after ring
    defaults(); postNever = 1;
    runCmd(16'h0006, 21'd1, 21'd1, 0);
    chk(gotStat == 2 && gotLen == 0, "R7 post timeout", gotStat, 2);
    chk(gotCyc >= LIMIT, "R7 post not early", gotCyc, LIMIT);
    chk(!logHas(3'd2), "R7 no status read on timeout", logHas(3'd2), 0);

    // stalled read crosses the limit, doorbell cleared meanwhile
    defaults(); ackDelay = 60; postHold = 20; devLen = 33;
    runCmd(16'h0007, 21'd1, 21'd50, 0);
    chk(gotStat == 0 && gotLen == 33, "R7 final sample clear", gotStat, 0);
    defaults(); ackDelay = 60; postNever = 1;
    runCmd(16'h0008, 21'd1, 21'd50, 0);
    chk(gotStat == 2, "R7 final sample set", gotStat, 2);

    // nonzero return code
    defaults(); rcVal = 16'h0042; devLen = 30;
    runCmd(16'h0009, 21'd1, 21'd40, 0);
    chk(gotStat == 0 && gotRc == 16'h0042 && gotLen == 0, "R8 return code", gotRc, 16'h42);
    chk(opLog[logCnt-1] == 3'd2 && !logHas(3'd1), "R8 no length read", opLog[logCnt-1], 2);

    // request while busy is dropped
    defaults(); postHold = 8; devLen = 4;
    runCmd(16'h0A0B, 21'd6, 21'd9, 3);
    chk(lastCmd[15:0] == 16'h0A0B && lastCmd[36:16] == 21'd6, "R2 second request ignored",
        lastCmd[15:0], 16'h0A0B);
    chk(gotStat == 0 && gotLen == 4, "R2 first command result", gotLen, 4);
    repeat (10) @(negedge clk);
    chk(!busy && !regReq, "R2 no restart", {busy, regReq}, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule